// File: doc/BRIEF.md
# Car Wash Stage Sequencer

This block is a clocked Moore state machine that steps an automatic car wash through its stages. A wash begins from the idle stage when the start input is raised. The machine then walks through a first rinse, soap spray, scrub and a second rinse, spending one clock in each stage.

At the second rinse the deluxe input selects the rest of the wash. If deluxe is low, the machine returns to idle. If deluxe is high, it carries on through wax, a third rinse and drying before it goes back to idle. A kill input aborts any stage and forces idle on the next clock.

The block drives eight one-hot stage indicators and a three-bit stage code that can be observed. Both are registered, so they change only on a rising clock edge. Reset is synchronous and active high.

Top module: `carwash_seq`

## Requirements
- R1: While rst is high at a rising edge, the next state is idle: stage_code_o = 000 and stage_led_o = 00000001. Reset has priority over kill_i, start_i and deluxe_i.
- R2: In idle (000), with kill_i low, the stage stays idle when start_i is low and moves to first rinse (001) when start_i is high.
- R3: From first rinse (001), soap (010) and scrub (011), with kill_i low, the code advances by one per clock: 001→010→011→100.
- R4: In second rinse (100), with deluxe_i high and kill_i low, the next stage is wax (101). The machine then steps to third rinse (110), then dry (111), then idle (000), one per clock when kill_i is low.
- R5: In second rinse (100), with deluxe_i low and kill_i low, the next stage is idle (000).
- R6: When kill_i is high at a rising edge (and rst is low), the next stage is idle (000) from every stage, whatever start_i and deluxe_i are.
- R7: stage_led_o is one-hot: bit n is high exactly when stage_code_o equals n, so bit 0 marks idle and bit 7 marks dry. Both outputs are registered and change only on a rising clock edge.
- R8: deluxe_i has no effect in any stage other than second rinse (100), and start_i has no effect in any stage other than idle (000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to idle |
| start_i | input | 1 | Begins a wash when the machine is idle |
| deluxe_i | input | 1 | At second rinse, selects the extended wash |
| kill_i | input | 1 | Aborts to idle on the next clock |
| stage_code_o | output | 3 | Registered current stage code (000 idle … 111 dry) |
| stage_led_o | output | 8 | Registered one-hot stage indicators, bit n for code n |

## Verification
The assertions assume that start_i, deluxe_i and kill_i are synchronous to clk, never X or Z, and stable around each rising edge. They also assume rst is held high for the first edge, so the state is defined before any transition property is evaluated. The bench meets these assumptions by driving every input with a 0 or 1 only at falling edges and by opening with a reset cycle. Its stimulus comes from directed sequences and from a linear-feedback generator whose kill rate is kept low, so that long deluxe runs still occur.

// File: rtl/carwash_pkg.sv
package carwash_pkg;

  localparam int STAGE_COUNT = 8;
  localparam int CODE_W      = $clog2(STAGE_COUNT);

  typedef enum logic [CODE_W-1:0] {
    ST_IDLE    = 3'd0,
    ST_RINSE_A = 3'd1,
    ST_SOAP    = 3'd2,
    ST_SCRUB   = 3'd3,
    ST_RINSE_B = 3'd4,
    ST_WAX     = 3'd5,
    ST_RINSE_C = 3'd6,
    ST_DRY     = 3'd7
  } stage_t;

endpackage

// File: rtl/cw_next_stage.sv
module cw_next_stage
  import carwash_pkg::*;
(
  input  stage_t cur_i,
  input  logic   start_i,
  input  logic   deluxe_i,
  input  logic   kill_i,
  output stage_t nxt_o
);

  always_comb begin
    nxt_o = ST_IDLE;
    if (!kill_i) begin
      unique case (cur_i)
        ST_IDLE:    nxt_o = start_i ? ST_RINSE_A : ST_IDLE;
        ST_RINSE_A: nxt_o = ST_SOAP;
        ST_SOAP:    nxt_o = ST_SCRUB;
        ST_SCRUB:   nxt_o = ST_RINSE_B;
        ST_RINSE_B: nxt_o = deluxe_i ? ST_WAX : ST_IDLE;
        ST_WAX:     nxt_o = ST_RINSE_C;
        ST_RINSE_C: nxt_o = ST_DRY;
        ST_DRY:     nxt_o = ST_IDLE;
        default:    nxt_o = ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cw_stage_decode.sv
module cw_stage_decode #(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input  logic [W-1:0] code_i,
  output logic [N-1:0] onehot_o
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    assign onehot_o[g] = (code_i == W'(g));
  end

endmodule

// File: rtl/carwash_seq.sv
module carwash_seq
  import carwash_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic                   deluxe_i,
  input  logic                   kill_i,
  output logic [CODE_W-1:0]      stage_code_o,
  output logic [STAGE_COUNT-1:0] stage_led_o
);

  stage_t                 stage_q;
  stage_t                 stage_d;
  logic [STAGE_COUNT-1:0] led_d;
  logic [STAGE_COUNT-1:0] led_q;

  cw_next_stage u_next (
    .cur_i    (stage_q),
    .start_i  (start_i),
    .deluxe_i (deluxe_i),
    .kill_i   (kill_i),
    .nxt_o    (stage_d)
  );

  // Decode the upcoming stage so the indicators are registered with the code.
  cw_stage_decode #(
    .N (STAGE_COUNT),
    .W (CODE_W)
  ) u_dec (
    .code_i   (stage_d),
    .onehot_o (led_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= ST_IDLE;
      led_q   <= STAGE_COUNT'(1);
    end else begin
      stage_q <= stage_d;
      led_q   <= led_d;
    end
  end

  assign stage_code_o = stage_q;
  assign stage_led_o  = led_q;

endmodule

// File: rtl/carwash_seq_chk.sv
module carwash_seq_chk #(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic         deluxe_i,
  input logic         kill_i,
  input logic [W-1:0] stage_code_o,
  input logic [N-1:0] stage_led_o
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (stage_code_o == '0 && stage_led_o == N'(1)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stage_code_o == W'(0) && !start_i && !kill_i) |=> stage_code_o == W'(0));

  // R2
  idle_go_chk: assert property (@(posedge clk) disable iff (rst)
    (stage_code_o == W'(0) && start_i && !kill_i) |=> stage_code_o == W'(1));

  // R3
  front_step_chk: assert property (@(posedge clk) disable iff (rst)
    (stage_code_o >= W'(1) && stage_code_o <= W'(3) && !kill_i)
      |=> stage_code_o == W'($past(stage_code_o) + W'(1)));

  // R4
  deluxe_take_chk: assert property (@(posedge clk) disable iff (rst)
    (stage_code_o == W'(4) && deluxe_i && !kill_i) |=> stage_code_o == W'(5));

  // R4
  back_step_chk: assert property (@(posedge clk) disable iff (rst)
    (stage_code_o >= W'(5) && stage_code_o <= W'(6) && !kill_i)
      |=> stage_code_o == W'($past(stage_code_o) + W'(1)));

  // R4
  dry_done_chk: assert property (@(posedge clk) disable iff (rst)
    (stage_code_o == W'(7) && !kill_i) |=> stage_code_o == W'(0));

  // R5
  normal_end_chk: assert property (@(posedge clk) disable iff (rst)
    (stage_code_o == W'(4) && !deluxe_i && !kill_i) |=> stage_code_o == W'(0));

  // R6
  kill_abort_chk: assert property (@(posedge clk) disable iff (rst)
    kill_i |=> stage_code_o == W'(0));

  // R7
  led_match_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stage_led_o) && stage_led_o == (N'(1) << stage_code_o));

  // R7
  led_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (stage_code_o == $past(stage_code_o)) |-> $stable(stage_led_o));

endmodule

bind carwash_seq carwash_seq_chk #(
  .N (carwash_pkg::STAGE_COUNT),
  .W (carwash_pkg::CODE_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .deluxe_i     (deluxe_i),
  .kill_i       (kill_i),
  .stage_code_o (stage_code_o),
  .stage_led_o  (stage_led_o)
);

// File: tb/tb_carwash_seq.sv
`timescale 1ns/1ps
module tb_carwash_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       deluxe_i = 1'b0;
  logic       kill_i = 1'b0;
  logic [2:0] stage_code_o;
  logic [7:0] stage_led_o;

  int vec_cnt  = 0;
  int miss_cnt = 0;
  int model    = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  carwash_seq dut (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .deluxe_i     (deluxe_i),
    .kill_i       (kill_i),
    .stage_code_o (stage_code_o),
    .stage_led_o  (stage_led_o)
  );

  function automatic int ref_next(int cur, bit r, bit s, bit d, bit k);
    if (r || k) return 0;
    if (cur == 0) return s ? 1 : 0;
    if (cur == 4) return d ? 5 : 0;
    if (cur == 7) return 0;
    return cur + 1;
  endfunction

  function automatic string tag_of(int cur, bit r, bit s, bit d, bit k);
    string t;
    if (r)                 t = "R1";
    else if (k)            t = "R6";
    else if (cur == 0)     t = "R2";
    else if (cur <= 3)     t = "R3";
    else if (cur == 4)     t = d ? "R4" : "R5";
    else                   t = "R4";
    if (!r && !k && ((d && cur != 4) || (s && cur != 0))) t = {t, "+R8"};
    return t;
  endfunction

  task automatic step(bit r, bit s, bit d, bit k);
    int    exp_code;
    string tg;
    rst = r; start_i = s; deluxe_i = d; kill_i = k;
    exp_code = ref_next(model, r, s, d, k);
    tg       = tag_of(model, r, s, d, k);
    @(posedge clk);
    @(negedge clk);
    vec_cnt++;
    if (stage_code_o !== 3'(exp_code)) begin
      miss_cnt++;
      $display("FAIL %s: stage code %b expected %b (from %0d, r%0b s%0b d%0b k%0b)",
               tg, stage_code_o, 3'(exp_code), model, r, s, d, k);
    end
    vec_cnt++;
    if (stage_led_o !== (8'd1 << exp_code)) begin
      miss_cnt++;
      $display("FAIL R7: stage leds %b expected %b", stage_led_o, 8'd1 << exp_code);
    end
    model = exp_code;
  endtask

  initial begin
    #4_000_000;
    miss_cnt++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset wins over kill and start
    step(1, 1, 1, 1);
    step(1, 1, 0, 0);
    // R2: idle holds without start, deluxe ignored in idle (R8)
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    // R2/R3/R5: normal wash, start dropped and toggled mid-run (R8)
    step(0, 1, 0, 0);
    step(0, 0, 1, 0);
    step(0, 1, 1, 0);
    step(0, 0, 0, 0);
    step(0, 1, 0, 0);
    step(0, 0, 0, 0);
    // R2/R4: deluxe wash with start ignored in back half (R8)
    step(0, 1, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0);
    step(0, 0, 1, 0);
    step(0, 1, 0, 0);
    step(0, 1, 1, 0);
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    // R6: kill from every stage
    for (int st = 1; st < 8; st++) begin
      step(0, 1, 0, 0);
      for (int j = 1; j < st; j++) step(0, 0, (j == 4), 0);
      step(0, 1, 1, 1);
    end
    // R6: kill in idle with start high
    step(0, 1, 0, 1);
    // R1: reset in the middle of a deluxe run
    step(0, 1, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0);
    step(0, 0, 1, 0);
    step(1, 1, 1, 0);
    // Mixed pseudo-random traffic
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[7:0] == 8'h00, lfsr[2], lfsr[5], lfsr[11:8] == 4'hF);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
    $finish;
  end

endmodule